// File: doc/BRIEF.md
# AES-128 Block Decryption Engine (ECB)

This block turns one 128-bit ciphertext block into its plaintext under AES-128 in electronic-codebook mode. It does not expand the key itself. It reads an already expanded forward schedule (the ten round keys after the cipher key) together with the cipher key, and it applies them from last to first. Encryption logic elsewhere can therefore hold the one schedule that both directions use.

A single inverse-round datapath is reused for every round. Each accepted block spends one cycle on the initial key addition and then one cycle per inverse round. Ciphertext enters through a ready/valid pair. Plaintext leaves through a second, independent ready/valid pair. A new block is taken only when the shared schedule is marked valid and the previous result has been handed over.

Bytes are packed least-significant first: bits [7:0] of a 128-bit word are state byte 0, bits [15:8] are byte 1, and so on. Byte index i sits in row i mod 4 and column i div 4.

Top module: `aes128_ecb_decrypt`

## Requirements
- R1: In the first cycle after a synchronous active-low reset is released, `pt_valid` is 0 and `ct_ready` equals `key_valid`.
- R2: While `key_valid` is 0, `ct_ready` stays 0 and a ciphertext offered with `ct_valid` = 1 is not taken, so `pt_valid` stays 0.
- R3: With the 16 bytes packed least-significant byte first, the 128-bit key 000102…0f and ciphertext 69c4e0d8…c55a (byte 0 listed first) give the plaintext 00112233…eeff.
- R4: `pt_valid` first reads 1 in the cycle after the tenth rising edge that follows the edge on which `ct_valid` and `ct_ready` were both 1.
- R5: While `pt_valid` is 1 and `pt_ready` is 0, `pt_valid` stays 1 and `pt_data` does not change.
- R6: From the edge that accepts a ciphertext until the edge on which the plaintext is taken (`pt_valid` and `pt_ready` both 1), `ct_ready` is 0, and any ciphertext offered in that interval is discarded.
- R7: In the cycle after the plaintext is taken, `pt_valid` is 0 and `ct_ready` is 1 when `key_valid` is 1, so blocks can follow one another with no idle gap beyond that cycle.
- R8: For any key and plaintext, when `round_keys` entry k (bits [128k+127:128k]) carries the round-(k+1) key of the forward schedule, the output equals the plaintext that was encrypted to the presented ciphertext.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| key_valid | input | 1 | Schedule and cipher key are usable |
| cipher_key | input | 128 | Original AES-128 key (round-0 key) |
| round_keys | input | 1280 | Forward schedule, entry k = round-(k+1) key at bits [128k+127:128k] |
| ct_valid | input | 1 | Ciphertext block offered |
| ct_ready | output | 1 | Engine can take a ciphertext block |
| ct_data | input | 128 | Ciphertext block, byte 0 in bits [7:0] |
| pt_valid | output | 1 | Plaintext block available |
| pt_ready | input | 1 | Consumer takes the plaintext block |
| pt_data | output | 128 | Plaintext block, byte 0 in bits [7:0] |

## Verification
The bench builds the engine with its default round count of ten, which is the only value that gives a true AES-128 schedule. This lets it feed the published AES-128 vectors and blocks from its own forward cipher and key expansion. The full reverse walk through the ten schedule entries and the cipher key is exercised in every block. So are the omitted final column mix, the ten-edge latency, and the handshake corners: schedule not yet valid, a stalled consumer, and ciphertext offered while busy.

// File: rtl/aes_inv_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the AES-128 decryption engine.
// Holds the controller state type and GF(2^8) helpers (field polynomial 0x11B).
// The inverse S-box is computed (inverse affine map, then field inversion),
// so no lookup table is stored.
package aes_inv_pkg;

    localparam int BYTE_W = 8;
    localparam int ROWS   = 4;
    localparam int COLS   = 4;
    localparam int NBYTES = ROWS * COLS;
    localparam int BLK_W  = NBYTES * BYTE_W;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_DONE = 2'd2
    } dec_state_e;

    // Multiply by x modulo the AES field polynomial.
    function automatic byte_t gf_xtime(input byte_t a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    // General field multiply by shift-and-add.
    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t acc;
        byte_t sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_xtime(sh);
        end
        return acc;
    endfunction

    // Inverse S-box: undo the affine step, then raise to the power 254.
    function automatic byte_t inv_sbox(input byte_t x);
        byte_t y;
        byte_t pw;
        byte_t res;
        for (int i = 0; i < BYTE_W; i++) begin
            y[i] = x[(i + 2) % BYTE_W] ^ x[(i + 5) % BYTE_W] ^ x[(i + 7) % BYTE_W];
        end
        y   = y ^ 8'h05;
        pw  = y;
        res = 8'h01;
        for (int i = 1; i < BYTE_W; i++) begin
            pw  = gf_mul(pw, pw);
            res = gf_mul(res, pw);
        end
        return res;
    endfunction

endpackage

// File: rtl/aes_inv_shift_sub.sv
`timescale 1ns/1ps
// Combined inverse row rotation and inverse byte substitution.
// Assumes byte i of the state is row i%ROWS, column i/ROWS; row r is rotated
// right by r columns, and each moved byte passes through the inverse S-box.
module aes_inv_shift_sub
    import aes_inv_pkg::*;
(
    input  logic [BLK_W-1:0] state_in,
    output logic [BLK_W-1:0] state_out
);

    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        localparam int R   = i % ROWS;
        localparam int C   = i / ROWS;
        localparam int SRC = R + ROWS * ((C - R + COLS) % COLS);
        // Pick the source byte of the rotated row and substitute it.
        assign state_out[i*BYTE_W +: BYTE_W] = inv_sbox(state_in[SRC*BYTE_W +: BYTE_W]);
    end

endmodule

// File: rtl/aes_inv_mix_columns.sv
`timescale 1ns/1ps
// Inverse column mixing: each 4-byte column is multiplied by the circulant
// matrix with first row {0E, 0B, 0D, 09} over GF(2^8).
// Assumes column c is formed by bytes 4c..4c+3 (row 0 in the lowest byte).
module aes_inv_mix_columns
    import aes_inv_pkg::*;
(
    input  logic [BLK_W-1:0] state_in,
    output logic [BLK_W-1:0] state_out
);

    for (genvar c = 0; c < COLS; c++) begin : g_col
        byte_t a0, a1, a2, a3;
        assign a0 = state_in[(ROWS*c + 0)*BYTE_W +: BYTE_W];
        assign a1 = state_in[(ROWS*c + 1)*BYTE_W +: BYTE_W];
        assign a2 = state_in[(ROWS*c + 2)*BYTE_W +: BYTE_W];
        assign a3 = state_in[(ROWS*c + 3)*BYTE_W +: BYTE_W];
        // One output row per rotation of the coefficient vector.
        assign state_out[(ROWS*c + 0)*BYTE_W +: BYTE_W] =
            gf_mul(a0, 8'h0e) ^ gf_mul(a1, 8'h0b) ^ gf_mul(a2, 8'h0d) ^ gf_mul(a3, 8'h09);
        assign state_out[(ROWS*c + 1)*BYTE_W +: BYTE_W] =
            gf_mul(a0, 8'h09) ^ gf_mul(a1, 8'h0e) ^ gf_mul(a2, 8'h0b) ^ gf_mul(a3, 8'h0d);
        assign state_out[(ROWS*c + 2)*BYTE_W +: BYTE_W] =
            gf_mul(a0, 8'h0d) ^ gf_mul(a1, 8'h09) ^ gf_mul(a2, 8'h0e) ^ gf_mul(a3, 8'h0b);
        assign state_out[(ROWS*c + 3)*BYTE_W +: BYTE_W] =
            gf_mul(a0, 8'h0b) ^ gf_mul(a1, 8'h0d) ^ gf_mul(a2, 8'h09) ^ gf_mul(a3, 8'h0e);
    end

endmodule

// File: rtl/aes_inv_round.sv
`timescale 1ns/1ps
// One inverse AES round, purely combinational.
// Order: inverse rotate/substitute, add the round key, then inverse column mix.
// The column mix is skipped when final_round is set.
module aes_inv_round
    import aes_inv_pkg::*;
(
    input  logic [BLK_W-1:0] state_in,
    input  logic [BLK_W-1:0] round_key,
    input  logic             final_round,
    output logic [BLK_W-1:0] state_out
);

    logic [BLK_W-1:0] subbed;
    logic [BLK_W-1:0] keyed;
    logic [BLK_W-1:0] mixed;

    aes_inv_shift_sub u_shift_sub (
        .state_in  (subbed_src()),
        .state_out (subbed)
    );

    function automatic logic [BLK_W-1:0] subbed_src();
        return state_in;
    endfunction

    assign keyed = subbed ^ round_key;

    aes_inv_mix_columns u_mix (
        .state_in  (keyed),
        .state_out (mixed)
    );

    // Final round leaves the column mix out.
    always_comb begin
        state_out = final_round ? keyed : mixed;
    end

endmodule

// File: rtl/aes_inv_ctrl.sv
`timescale 1ns/1ps
// Sequencer for the iterative decryption engine.
// Takes a block only when idle and the schedule is valid, then counts NR
// inverse rounds down to zero, then holds the result until it is taken.
// Assumes the schedule inputs stay stable while a block is in flight.
module aes_inv_ctrl
    import aes_inv_pkg::*;
#(
    parameter int NR    = 10,
    localparam int CNT_W = $clog2(NR)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_valid,
    input  logic             ct_valid,
    input  logic             pt_ready,
    output logic             ct_ready,
    output logic             pt_valid,
    output logic             load,
    output logic             step,
    output logic             final_round,
    output logic [CNT_W-1:0] round_cnt
);

    dec_state_e       st_q;
    logic [CNT_W-1:0] cnt_q;

    // Advance the block state and the round counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (ct_valid && key_valid) begin
                        st_q  <= ST_BUSY;
                        cnt_q <= CNT_W'(NR - 1);
                    end
                end
                ST_BUSY: begin
                    if (cnt_q == '0) st_q  <= ST_DONE;
                    else             cnt_q <= cnt_q - CNT_W'(1);
                end
                ST_DONE: begin
                    if (pt_ready) st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Decode handshake and datapath controls from the state.
    always_comb begin
        ct_ready    = (st_q == ST_IDLE) && key_valid;
        pt_valid    = (st_q == ST_DONE);
        load        = ct_ready && ct_valid;
        step        = (st_q == ST_BUSY);
        final_round = (cnt_q == '0);
        round_cnt   = cnt_q;
    end

endmodule

// File: rtl/aes128_ecb_decrypt.sv
`timescale 1ns/1ps
// Iterative AES-128 ECB decryption engine.
// Walks a forward key schedule backwards: the initial key addition uses
// entry NR-1, inverse rounds use entries NR-2 down to 0, and the last round
// uses the cipher key. One round per cycle through a single round datapath.
// Byte 0 of every 128-bit word is bits [7:0].
module aes128_ecb_decrypt #(
    parameter int NR = 10,
    localparam int BW    = aes_inv_pkg::BLK_W,
    localparam int SCH_W = NR * BW,
    localparam int CNT_W = $clog2(NR)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_valid,
    input  logic [BW-1:0]    cipher_key,
    input  logic [SCH_W-1:0] round_keys,
    input  logic             ct_valid,
    output logic             ct_ready,
    input  logic [BW-1:0]    ct_data,
    output logic             pt_valid,
    input  logic             pt_ready,
    output logic [BW-1:0]    pt_data
);

    logic [BW-1:0]    sched [NR];
    logic [BW-1:0]    state_q;
    logic [BW-1:0]    round_out;
    logic [BW-1:0]    rk_sel;
    logic [CNT_W-1:0] round_cnt;
    logic [CNT_W-1:0] cnt_m1;
    logic             load;
    logic             step;
    logic             final_round;

    for (genvar k = 0; k < NR; k++) begin : g_sched
        assign sched[k] = round_keys[k*BW +: BW];
    end

    aes_inv_ctrl #(.NR(NR)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .key_valid   (key_valid),
        .ct_valid    (ct_valid),
        .pt_ready    (pt_ready),
        .ct_ready    (ct_ready),
        .pt_valid    (pt_valid),
        .load        (load),
        .step        (step),
        .final_round (final_round),
        .round_cnt   (round_cnt)
    );

    // Pick the round key: cipher key last, otherwise schedule entry count-1.
    always_comb begin
        cnt_m1 = round_cnt - CNT_W'(1);
        rk_sel = final_round ? cipher_key : sched[cnt_m1];
    end

    aes_inv_round u_round (
        .state_in    (state_q),
        .round_key   (rk_sel),
        .final_round (final_round),
        .state_out   (round_out)
    );

    // State register: whitened load, then one inverse round per busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)    state_q <= '0;
        else if (load) state_q <= ct_data ^ sched[NR-1];
        else if (step) state_q <= round_out;
    end

    assign pt_data = state_q;

endmodule

// File: rtl/aes128_ecb_decrypt_chk.sv
`timescale 1ns/1ps
// Protocol and timing checker for the decryption engine, bound to the top.
// Tracks cycles since acceptance with a counter instead of a long delay.
module aes128_ecb_decrypt_chk #(
    parameter int NR = 10,
    localparam int BW    = aes_inv_pkg::BLK_W,
    localparam int LAT_W = $clog2(NR + 3)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          key_valid,
    input logic          ct_valid,
    input logic          ct_ready,
    input logic          pt_valid,
    input logic          pt_ready,
    input logic [BW-1:0] pt_data
);

    logic [LAT_W-1:0] lat_q;

    // Count edges from acceptance until the result shows up.
    always_ff @(posedge clk) begin
        if (!rst_n)                      lat_q <= '0;
        else if (ct_valid && ct_ready)   lat_q <= LAT_W'(1);
        else if (lat_q != '0 && !pt_valid) lat_q <= lat_q + LAT_W'(1);
    end

    // R1: no output pending right after reset release
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !pt_valid);

    // R2: never ready without a valid schedule
    a_r2_ready_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
        ct_ready |-> key_valid);

    // R4: result arrives on the tenth edge after acceptance
    a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pt_valid) |-> lat_q == LAT_W'(NR + 1));

    // R5: result held while the consumer stalls
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_valid && !pt_ready) |=> (pt_valid && $stable(pt_data)));

    // R6: no new block while one is in flight or pending
    a_r6_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (ct_valid && ct_ready) |=> !ct_ready);

    // R6: no ready while a result is pending
    a_r6_pending_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        pt_valid |-> !ct_ready);

endmodule

bind aes128_ecb_decrypt aes128_ecb_decrypt_chk #(.NR(NR)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_valid (key_valid),
    .ct_valid  (ct_valid),
    .ct_ready  (ct_ready),
    .pt_valid  (pt_valid),
    .pt_ready  (pt_ready),
    .pt_data   (pt_data)
);

// File: tb/aes128_ecb_decrypt_tb_top.sv
`timescale 1ns/1ps
// Directed bench: an independent forward AES-128 model produces schedules
// and ciphertexts; each task drives one scenario and checks its own results.
module aes128_ecb_decrypt_tb_top;

    localparam int NR = 10;
    localparam int BW = 128;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             key_valid = 1'b0;
    logic [BW-1:0]    cipher_key = '0;
    logic [NR*BW-1:0] round_keys = '0;
    logic             ct_valid = 1'b0;
    logic             ct_ready;
    logic [BW-1:0]    ct_data = '0;
    logic             pt_valid;
    logic             pt_ready = 1'b0;
    logic [BW-1:0]    pt_data;

    int checks = 0;
    int fails  = 0;
    logic [BW-1:0] rk_m [NR+1];

    always #4 clk = ~clk;

    aes128_ecb_decrypt #(.NR(NR)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_valid  (key_valid),
        .cipher_key (cipher_key),
        .round_keys (round_keys),
        .ct_valid   (ct_valid),
        .ct_ready   (ct_ready),
        .ct_data    (ct_data),
        .pt_valid   (pt_valid),
        .pt_ready   (pt_ready),
        .pt_data    (pt_data)
    );

    task automatic check(input bit ok, input string req, input logic [BW-1:0] act,
                         input logic [BW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // ---------------- independent forward model ----------------
    function automatic logic [7:0] m_xt(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p = 8'h00;
        logic [7:0] s = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p ^= s;
            s = m_xt(s);
        end
        return p;
    endfunction

    function automatic logic [7:0] m_rotl(input logic [7:0] b, input int n);
        return (b << n) | (b >> (8 - n));
    endfunction

    function automatic logic [7:0] m_sbox(input logic [7:0] x);
        logic [7:0] inv = 8'h01;
        logic [7:0] p = x;
        for (int i = 1; i < 8; i++) begin
            p   = m_mul(p, p);
            inv = m_mul(inv, p);
        end
        return inv ^ m_rotl(inv, 1) ^ m_rotl(inv, 2) ^ m_rotl(inv, 3) ^ m_rotl(inv, 4) ^ 8'h63;
    endfunction

    function automatic logic [BW-1:0] bswap(input logic [BW-1:0] v);
        logic [BW-1:0] o;
        for (int i = 0; i < 16; i++) o[8*i +: 8] = v[8*(15-i) +: 8];
        return o;
    endfunction

    // Expand a key into rk_m and drive the engine's schedule inputs.
    task automatic load_key(input logic [BW-1:0] key);
        logic [31:0] w [44];
        logic [31:0] t;
        logic [7:0]  rc = 8'h01;
        for (int i = 0; i < 4; i++) w[i] = key[32*i +: 32];
        for (int i = 4; i < 44; i++) begin
            t = w[i-1];
            if (i % 4 == 0) begin
                t = {t[7:0], t[31:8]};
                for (int b = 0; b < 4; b++) t[8*b +: 8] = m_sbox(t[8*b +: 8]);
                t[7:0] ^= rc;
                rc = m_xt(rc);
            end
            w[i] = w[i-4] ^ t;
        end
        for (int r = 0; r <= NR; r++) rk_m[r] = {w[4*r+3], w[4*r+2], w[4*r+1], w[4*r]};
        cipher_key = key;
        for (int k = 0; k < NR; k++) round_keys[k*BW +: BW] = rk_m[k+1];
    endtask

    function automatic logic [BW-1:0] encrypt(input logic [BW-1:0] pt);
        logic [BW-1:0] s = pt ^ rk_m[0];
        logic [BW-1:0] n;
        logic [7:0] a0, a1, a2, a3;
        for (int r = 1; r <= NR; r++) begin
            for (int i = 0; i < 16; i++) s[8*i +: 8] = m_sbox(s[8*i +: 8]);
            for (int c = 0; c < 4; c++)
                for (int rr = 0; rr < 4; rr++)
                    n[8*(rr + 4*c) +: 8] = s[8*(rr + 4*((c + rr) % 4)) +: 8];
            s = n;
            if (r < NR) begin
                for (int c = 0; c < 4; c++) begin
                    a0 = s[8*(4*c)   +: 8]; a1 = s[8*(4*c+1) +: 8];
                    a2 = s[8*(4*c+2) +: 8]; a3 = s[8*(4*c+3) +: 8];
                    s[8*(4*c)   +: 8] = m_xt(a0) ^ m_xt(a1) ^ a1 ^ a2 ^ a3;
                    s[8*(4*c+1) +: 8] = a0 ^ m_xt(a1) ^ m_xt(a2) ^ a2 ^ a3;
                    s[8*(4*c+2) +: 8] = a0 ^ a1 ^ m_xt(a2) ^ m_xt(a3) ^ a3;
                    s[8*(4*c+3) +: 8] = m_xt(a0) ^ a0 ^ a1 ^ a2 ^ m_xt(a3);
                end
            end
            s = s ^ rk_m[r];
        end
        return s;
    endfunction

    // Offer one block, measure latency, take result, check R7 after it.
    task automatic run_block(input logic [BW-1:0] ct, input logic [BW-1:0] exp,
                             input string req);
        int n = 0;
        while (!ct_ready && n < 100) begin @(negedge clk); n++; end
        ct_valid = 1'b1;
        ct_data  = ct;
        @(posedge clk);
        @(negedge clk);
        ct_valid = 1'b0;
        n = 1;
        while (!pt_valid && n < 100) begin @(negedge clk); n++; end
        check(n == NR + 1, "R4 latency", BW'(n), BW'(NR + 1));
        check(pt_data == exp, req, pt_data, exp);
        pt_ready = 1'b1;
        @(negedge clk);
        pt_ready = 1'b0;
        check(!pt_valid && ct_ready, "R7 ready after handoff",
              BW'({pt_valid, ct_ready}), BW'(2'b01));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        key_valid = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!pt_valid && ct_ready, "R1 reset state", BW'({pt_valid, ct_ready}), BW'(2'b01));
    endtask

    task automatic t_key_gate();
        key_valid = 1'b0;
        ct_valid  = 1'b1;
        ct_data   = 128'h0123;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check(!ct_ready && !pt_valid, "R2 gated without key",
                  BW'({ct_ready, pt_valid}), BW'(0));
        end
        ct_valid  = 1'b0;
        key_valid = 1'b1;
        @(negedge clk);
        check(ct_ready && !pt_valid, "R2 ready once key valid",
              BW'({ct_ready, pt_valid}), BW'(2'b10));
    endtask

    task automatic t_fips();
        logic [BW-1:0] key = bswap(128'h000102030405060708090a0b0c0d0e0f);
        logic [BW-1:0] pt  = bswap(128'h00112233445566778899aabbccddeeff);
        logic [BW-1:0] ct  = bswap(128'h69c4e0d86a7b0430d8cdb78070b4c55a);
        logic [BW-1:0] k2  = bswap(128'h2b7e151628aed2a6abf7158809cf4f3c);
        logic [BW-1:0] p2  = bswap(128'h3243f6a8885a308d313198a2e0370734);
        logic [BW-1:0] c2  = bswap(128'h3925841d02dc09fbdc118597196a0b32);
        load_key(key);
        check(encrypt(pt) == ct, "R3 bench model vector", encrypt(pt), ct);
        run_block(ct, pt, "R3 published vector");
        load_key(k2);
        run_block(c2, p2, "R3 second published vector");
    endtask

    task automatic t_hold();
        logic [BW-1:0] pt = 128'hfeedface_0badf00d_12345678_9abcdef0;
        logic [BW-1:0] ct;
        logic [BW-1:0] seen;
        ct = encrypt(pt);
        ct_valid = 1'b1;
        ct_data  = ct;
        @(posedge clk);
        @(negedge clk);
        ct_valid = 1'b0;
        while (!pt_valid) @(negedge clk);
        seen = pt_data;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(pt_valid && pt_data == seen, "R5 held under stall", pt_data, seen);
        end
        check(seen == pt, "R5 held value correct", seen, pt);
        pt_ready = 1'b1;
        @(negedge clk);
        pt_ready = 1'b0;
    endtask

    task automatic t_busy_ignore();
        logic [BW-1:0] pa = 128'h11111111_22222222_33333333_44444444;
        logic [BW-1:0] pb = 128'haaaaaaaa_bbbbbbbb_cccccccc_dddddddd;
        int n = 0;
        ct_valid = 1'b1;
        ct_data  = encrypt(pa);
        @(posedge clk);
        @(negedge clk);
        ct_data = 128'hdeadbeef_deadbeef_deadbeef_deadbeef;
        while (!pt_valid && n < 100) begin
            check(!ct_ready, "R6 not ready while busy", BW'(ct_ready), BW'(0));
            @(negedge clk);
            n++;
        end
        check(!ct_ready, "R6 not ready while pending", BW'(ct_ready), BW'(0));
        check(pt_data == pa, "R6 first block intact", pt_data, pa);
        ct_valid = 1'b0;
        pt_ready = 1'b1;
        @(negedge clk);
        pt_ready = 1'b0;
        run_block(encrypt(pb), pb, "R6 offered junk discarded");
    endtask

    task automatic t_sweep();
        logic [BW-1:0] key;
        logic [BW-1:0] pt;
        for (int v = 0; v < 6; v++) begin
            key = {32'(v) * 32'h9e3779b9, 32'h7f4a7c15 ^ 32'(v), 32'(v) * 32'h85ebca6b, 32'hc2b2ae35};
            case (v)
                0: pt = '0;
                1: pt = '1;
                default: pt = {32'(v) * 32'h27d4eb2f, 32'h165667b1 + 32'(v), 32'(v) << 7, ~32'(v)};
            endcase
            load_key(key);
            run_block(encrypt(pt), pt, "R8 model round trip");
        end
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        load_key(bswap(128'h000102030405060708090a0b0c0d0e0f));
        t_reset();
        t_key_gate();
        t_fips();
        t_hold();
        t_busy_ignore();
        t_sweep();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule